// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a byte-wide interval timer with three separate 16-bit down-counters. It sits on a small register bus. A 2-bit offset picks one of the three count ports or the control port. A write to the control port either takes a snapshot of one channel's count or sets that channel's counting mode. A count value is always loaded as a low byte followed by a high byte. Reads also come back low byte first, then high byte. Each byte is either the live count or the frozen snapshot.

Counting advances only on cycles where the single-cycle `tick` enable is high. In the target system that enable is derived from a nominal 1,193,180 Hz time base. Each channel drives a terminal-count line, and its shape depends on the mode:
- mode 0 gives a single rising edge at the end of the count;
- mode 2 gives a periodic one-tick low pulse;
- mode 3 gives a square wave.

Only binary counting is provided. Single-byte access modes, the read-back command and gate inputs are not provided.

Top module: `pit3_timer`

## Requirements
- R1: After reset, all three `tc_out` bits are 0, every channel reads 0x00 then 0x00, no snapshot is pending, and both byte pointers of each channel point at the low byte.
- R2: Writing the low byte of a count halts the channel and forces its `tc_out` bit to 0. The following high-byte write forms the 16-bit reload value. It restarts counting only if that value is nonzero; a zero value leaves the channel halted.
- R3: In mode 0, a count of N reaches 0 after N ticks. `tc_out` then rises and stays high, and counting stops, until the next low-byte write to that channel.
- R4: In mode 2 with reload N, `tc_out` is high except while the count equals 1. After k ticks the count is N - (k mod N), so the line is low for one tick in every N.
- R5: In mode 3 with an even reload N, `tc_out` starts high after the high-byte write. It toggles every N/2 ticks.
- R6: A read at offsets 0 to 2 returns the low byte of the selected count, then the high byte on the next read, alternating.
- R7: A control write with bits 7:6 = channel and bits 5:4 = 00 snapshots that channel's count and forces its read pointer to the low byte. While the snapshot is pending:
  - reads return the snapshot bytes;
  - a further snapshot command is ignored;
  - the snapshot is released once its high byte has been read.
- R8: A read at offset 3 returns 0xFF.
- R9: The control byte uses bits 7:6 = channel, bits 5:4 = access, bits 3:1 = mode and bit 0 = BCD. The mode is updated only when all of the following hold:
  - the channel field is 0 to 2;
  - the access field is 11;
  - BCD = 0;
  - the mode is 0, 2 or 3.
  Any other control byte leaves that channel's mode, snapshot and count unchanged; in particular, channel field 11 changes nothing.
- R10: A channel's count changes only on a cycle with `tick` high or with a write to that channel's count port.
- R11: The three channels count independently. Loading or ticking one has no effect on the count or output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle count enable |
| bus_sel | input | 2 | Offset: 0 to 2 select a channel's count port, 3 selects the control port |
| bus_wr | input | 1 | Write strobe; takes priority over `bus_rd` |
| bus_rd | input | 1 | Read strobe; advances the read byte pointer at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read cycle, 0 otherwise |
| tc_out | output | 3 | Terminal-count output of each channel |

## Verification
A wrong byte pointer shows up on the very next read of that channel, as swapped or repeated bytes. A snapshot that is lost or overwritten shows up as a count that differs from the value frozen at the snapshot command. A miscounting down-counter shows up at `tc_out`, at the first tick where the edge should or should not occur. For mode 0 that is tick N; for modes 2 and 3 it is within one period. Control bytes that ought to be rejected are caught by reloading the channel and watching whether its output pattern still follows the earlier mode.

// File: rtl/pit3_timer.sv
module pit3_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [2:0] tc_out
);

  logic [2:0]  wr_hi_v, held_v;
  logic [5:0]  mode_v;
  logic [47:0] cnt_v, snap_v;
  logic [2:0][7:0] rd_byte;

  wire       ctl_wr   = bus_wr && bus_sel == 2'd3;
  wire [1:0] ctl_ch   = bus_wdata[7:6];
  wire [1:0] ctl_acc  = bus_wdata[5:4];
  wire [2:0] ctl_mode = bus_wdata[3:1];
  wire       ctl_ok   = ctl_acc == 2'd3 && !bus_wdata[0] &&
                        (ctl_mode == 3'd0 || ctl_mode == 3'd2 || ctl_mode == 3'd3);

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [15:0] cnt_q, rld_q, snap_q;
    logic [1:0]  mode_q;
    logic        run_q, done_q, phase_q, wr_hi_q, rd_hi_q, held_q, tc;

    wire data_wr = bus_wr && bus_sel == 2'(i);
    wire data_rd = bus_rd && !bus_wr && bus_sel == 2'(i);
    wire ctl_hit = ctl_wr && ctl_ch == 2'(i);
    wire [15:0] view = held_q ? snap_q : cnt_q;

    assign rd_byte[i] = rd_hi_q ? view[15:8] : view[7:0];

    always_comb begin
      case (mode_q)
        2'd2:    tc = run_q && cnt_q != 16'd1;
        2'd3:    tc = run_q && phase_q;
        default: tc = done_q;
      endcase
    end

    assign tc_out[i]           = tc;
    assign wr_hi_v[i]          = wr_hi_q;
    assign held_v[i]           = held_q;
    assign mode_v[2*i +: 2]    = mode_q;
    assign cnt_v[16*i +: 16]   = cnt_q;
    assign snap_v[16*i +: 16]  = snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        rld_q   <= '0;
        snap_q  <= '0;
        mode_q  <= '0;
        run_q   <= 1'b0;
        done_q  <= 1'b0;
        phase_q <= 1'b0;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
        held_q  <= 1'b0;
      end else begin
        if (ctl_hit && ctl_acc == 2'd0) begin
          if (!held_q) begin
            held_q  <= 1'b1;
            rd_hi_q <= 1'b0;
            snap_q  <= cnt_q;
          end
        end else if (ctl_hit && ctl_ok) begin
          mode_q <= ctl_mode[1:0];
        end

        if (data_rd) begin
          if (rd_hi_q) begin
            rd_hi_q <= 1'b0;
            held_q  <= 1'b0;
          end else begin
            rd_hi_q <= 1'b1;
          end
        end

        if (data_wr) begin
          if (!wr_hi_q) begin
            cnt_q[7:0] <= bus_wdata;
            run_q      <= 1'b0;
            done_q     <= 1'b0;
            wr_hi_q    <= 1'b1;
          end else begin
            cnt_q[15:8] <= bus_wdata;
            rld_q       <= {bus_wdata, cnt_q[7:0]};
            run_q       <= {bus_wdata, cnt_q[7:0]} != 16'd0;
            phase_q     <= 1'b1;
            wr_hi_q     <= 1'b0;
          end
        end else if (tick && run_q) begin
          case (mode_q)
            2'd2: cnt_q <= (cnt_q == 16'd1) ? rld_q : cnt_q - 16'd1;
            2'd3: begin
              if (cnt_q <= 16'd2) begin
                cnt_q   <= rld_q;
                phase_q <= ~phase_q;
              end else begin
                cnt_q <= cnt_q - 16'd2;
              end
            end
            default: begin
              if (cnt_q == 16'd1) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
                run_q  <= 1'b0;
              end else begin
                cnt_q <= cnt_q - 16'd1;
              end
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    if (!bus_rd) bus_rdata = 8'h00;
    else begin
      case (bus_sel)
        2'd0:    bus_rdata = rd_byte[0];
        2'd1:    bus_rdata = rd_byte[1];
        2'd2:    bus_rdata = rd_byte[2];
        default: bus_rdata = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/pit3_timer_chk.sv
module pit3_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [1:0]  bus_sel,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [1:0]  ctl_sel,
  input logic [7:0]  bus_rdata,
  input logic [2:0]  tc_out,
  input logic [2:0]  wr_hi_v,
  input logic [2:0]  held_v,
  input logic [5:0]  mode_v,
  input logic [47:0] cnt_v,
  input logic [47:0] snap_v
);

  p_ctrl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd3) |-> bus_rdata == 8'hFF);

  p_readback_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && ctl_sel == 2'd3) |=> ($stable(mode_v) && $stable(held_v)));

  for (genvar i = 0; i < 3; i++) begin : g_p
    p_lowbyte_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'(i) && !wr_hi_v[i]) |=> !tc_out[i]);

    p_mode0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[2*i +: 2] == 2'd0 && tc_out[i] && !(bus_wr && bus_sel == 2'(i)) &&
       !(bus_wr && bus_sel == 2'd3)) |=> tc_out[i]);

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      held_v[i] |=> (!held_v[i] || $stable(snap_v[16*i +: 16])));

    p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(bus_wr && bus_sel == 2'(i))) |=> $stable(cnt_v[16*i +: 16]));
  end

endmodule

bind pit3_timer pit3_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .ctl_sel(bus_wdata[7:6]), .bus_rdata(bus_rdata), .tc_out(tc_out),
  .wr_hi_v(wr_hi_v), .held_v(held_v), .mode_v(mode_v), .cnt_v(cnt_v), .snap_v(snap_v)
);

// File: tb/pit3_timer_bench.sv
module pit3_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] tc_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  pit3_timer u_pit3_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_out(tc_out)
  );

  always #5 clk = ~clk;

  function automatic int exp_m2_tc(int n, int k);
    return ((n - (k % n)) != 1) ? 1 : 0;
  endfunction

  function automatic int exp_m3_tc(int n, int k);
    return (((k / (n / 2)) % 2) == 0) ? 1 : 0;
  endfunction

  function automatic int exp_m0_tc(int n, int k);
    return (k >= n) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic read16(input logic [1:0] s, output int v);
    logic [7:0] lo, hi;
    bus_read(s, lo);
    bus_read(s, hi);
    v = {16'd0, hi, lo};
  endtask

  task automatic ticks(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic load(input logic [1:0] ch, input logic [2:0] mode, input int val);
    bus_write(2'd3, {ch, 2'b11, mode, 1'b0});
    bus_write(ch, val[7:0]);
    bus_write(ch, val[15:8]);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, n0, n1, k;
    logic [7:0] b;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check("R1 tc after reset", int'(tc_out), 0);
    for (int c = 0; c < 3; c++) begin
      read16(2'(c), v);
      check("R1 count after reset", v, 0);
    end
    bus_read(2'd3, b);
    check("R8 control read", int'(b), 8'hFF);

    load(2'd0, 3'd0, 0);
    ticks(5);
    check("R2 zero reload halted tc", int'(tc_out[0]), 0);
    read16(2'd0, v);
    check("R2 zero reload count", v, 0);

    load(2'd0, 3'd0, 300);
    ticks(150);
    read16(2'd0, v);
    check("R3 mid count", v, 150);
    check("R3 tc low mid", int'(tc_out[0]), 0);
    ticks(149);
    check("R3 tc low at 1", int'(tc_out[0]), 0);
    ticks(1);
    check("R3 tc high at 0", int'(tc_out[0]), 1);
    read16(2'd0, v);
    check("R3 count at 0", v, 0);
    ticks(5);
    check("R3 tc stays high", int'(tc_out[0]), 1);
    bus_write(2'd0, 8'h10);
    #1 check("R2 low byte clears tc", int'(tc_out[0]), 0);
    bus_write(2'd0, 8'h00);

    load(2'd1, 3'd0, 10);
    repeat (20) @(negedge clk);
    read16(2'd1, v);
    check("R10 no tick no change", v, 10);

    load(2'd2, 3'd0, 16'h1234);
    bus_read(2'd2, b);
    check("R6 low byte first", int'(b), 8'h34);
    bus_read(2'd2, b);
    check("R6 high byte second", int'(b), 8'h12);

    load(2'd0, 3'd0, 1000);
    ticks(100);
    bus_read(2'd0, b);
    check("R6 live low", int'(b), 900 & 8'hFF);
    bus_write(2'd3, 8'h00);
    ticks(50);
    bus_read(2'd0, b);
    check("R7 snapshot low after pointer reset", int'(b), 900 & 8'hFF);
    bus_write(2'd3, 8'h00);
    ticks(10);
    bus_read(2'd0, b);
    check("R7 second latch ignored", int'(b), 900 >> 8);
    read16(2'd0, v);
    check("R7 released to live", v, 840);

    load(2'd1, 3'd2, 5);
    check("R4 tc after load", int'(tc_out[1]), 1);
    for (int kk = 1; kk <= 12; kk++) begin
      ticks(1);
      check("R4 rate pattern", int'(tc_out[1]), exp_m2_tc(5, kk));
    end

    load(2'd2, 3'd3, 8);
    check("R5 tc after load", int'(tc_out[2]), 1);
    for (int kk = 1; kk <= 20; kk++) begin
      ticks(1);
      check("R5 square pattern", int'(tc_out[2]), exp_m3_tc(8, kk));
    end

    bus_write(2'd3, 8'b01_01_000_0);
    bus_write(2'd3, 8'b01_11_001_0);
    bus_write(2'd3, 8'b01_11_000_1);
    bus_write(2'd3, 8'b01_11_100_0);
    bus_write(2'd3, 8'b11_11_000_0);
    bus_write(2'd1, 8'd5);
    bus_write(2'd1, 8'd0);
    for (int kk = 1; kk <= 6; kk++) begin
      ticks(1);
      check("R9 mode kept after bad controls", int'(tc_out[1]), exp_m2_tc(5, kk));
    end
    load(2'd0, 3'd0, 500);
    bus_write(2'd3, 8'hC0);
    ticks(7);
    read16(2'd0, v);
    check("R9 read-back select takes no snapshot", v, 493);

    for (int it = 0; it < 6; it++) begin
      n0 = 2 + int'($urandom % 200);
      n1 = 2 + int'($urandom % 200);
      load(2'd0, 3'd0, n0);
      load(2'd1, 3'd0, n1);
      k = int'($urandom % ((n0 < n1) ? n0 : n1));
      ticks(k);
      read16(2'd0, v);
      check("R11 ch0 count", v, n0 - k);
      read16(2'd1, v);
      check("R11 ch1 count", v, n1 - k);
      check("R3 ch0 tc", int'(tc_out[0]), exp_m0_tc(n0, k));
      ticks(((n0 > n1) ? n0 : n1) - k);
      check("R3 both tc high", int'(tc_out[1:0]), 3);
    end

    for (int it = 0; it < 3; it++) begin
      n0 = 2 * (1 + int'($urandom % 20));
      load(2'd2, 3'd3, n0);
      for (int kk = 1; kk <= 2 * n0 + 1; kk++) begin
        ticks(1);
        check("R5 random square", int'(tc_out[2]), exp_m3_tc(n0, kk));
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule